// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block runs the internally timed programming cycle of a serial non-volatile memory after the serial front end has finished shifting in an erase or write command. The front end hands over a latched operation, word address, data word and a permit flag. The permit flag is the result of the enable and protection checks, which are made elsewhere. The cycle starts when chip select falls. The block then counts the system clock to model the program time, with no serial clock needed. At the end of each phase it drives one update strobe into a register-file memory model: either a single word or the whole array. Write-all is split into a whole-array erase phase and then a whole-array fill phase.

The block also produces the ready/busy status that the serial data-out pin shows. Status is enabled only when chip select is raised during a cycle after having been low for a minimum time. It then reads 0 while busy and 1 when done, and it is withdrawn on the next falling edge of chip select.

State machine `prog_seq_fsm`:
- ST_IDLE goes to ST_LOADED on a permitted command and stays put on a refused one.
- ST_LOADED goes to ST_LOADED on a new permitted command, to ST_IDLE on a refused one, to ST_WORD on a chip-select fall for a word operation, and to ST_CLEAR_ALL on a fall for an erase-all or write-all.
- ST_WORD goes to ST_IDLE when its timer expires.
- ST_CLEAR_ALL goes to ST_FILL_ALL on expiry for write-all, and to ST_IDLE on expiry for erase-all.
- ST_FILL_ALL goes to ST_IDLE on expiry.

Top module: `prog_seq`

## Requirements
- R1: While reset is held, and right after it, busy, dout_oe, mem_we and mem_we_all are all 0.
- R2: After a permitted command has been loaded, busy rises on the third rising clock edge after chip select falls: a two-stage synchronizer, then the edge detect, then the state register.
- R3: Busy stays high for exactly T_WORD_CLKS cycles for a word erase or write, T_ERAL_CLKS cycles for erase-all and T_WRAL_CLKS cycles for write-all.
- R4: A word write (cmd_op 2'b01) gives exactly one mem_we pulse, in the last busy cycle, carrying the latched address and data.
- R5: A word erase (cmd_op 2'b00) gives exactly one mem_we pulse carrying the latched address and data 16'hFFFF.
- R6: An erase-all (cmd_op 2'b10) gives exactly one mem_we_all pulse with data 16'hFFFF. mem_we and mem_we_all are never high together.
- R7: A write-all (cmd_op 2'b11) gives a mem_we_all pulse with 16'hFFFF at the end of the first T_ERAL_CLKS busy cycles, then a second mem_we_all pulse with the latched data in the last busy cycle.
- R8: A command offered with permit low starts no cycle, even when it replaces a command that was already loaded. Busy never rises and no strobe is produced.
- R9: If chip select rises during a cycle after having been low for at least MIN_LOW_CLKS synchronized cycles, dout_oe goes to 1. dout then reads 0 while busy and 1 after the cycle ends.
- R10: dout_oe stays 0 if chip select is low for a shorter time before rising, or is not raised during the cycle at all.
- R11: dout_oe returns to 0 on the detected falling edge of chip select.
- R12: A started cycle always runs to its end whatever chip select does, and a command offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, asynchronous to clk |
| cmd_valid | input | 1 | One-cycle pulse: a complete command is loaded |
| cmd_op | input | 2 | 00 erase word, 01 write word, 10 erase all, 11 write all |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of the command |
| permit | input | 1 | Command may execute (sampled with cmd_valid) |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Single-word update strobe |
| mem_we_all | output | 1 | Whole-array update strobe |
| mem_addr | output | ADDR_W | Word address for mem_we |
| mem_wdata | output | DATA_W | Data for either strobe |
| dout | output | 1 | Status value: 0 busy, 1 ready |
| dout_oe | output | 1 | Status drive enable for the data-out pin |

## Verification
The bench aims at the write-all ordering: a design that skipped the erase phase or swapped the two phases would deliver strobes that do not match the expected queue. It measures busy length per operation, which catches a timer that is off by one or loaded from the wrong phase limit. For status, it contrasts a long low pulse with a two-cycle glitch of chip select; a design with no low-time check would enable dout on the glitch. It also offers a refused command over a loaded one and a command during busy; a design that latched either would start a cycle on the next chip-select fall.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
    typedef enum logic [1:0] {
        OP_ERASE     = 2'b00,
        OP_WRITE     = 2'b01,
        OP_ERASE_ALL = 2'b10,
        OP_WRITE_ALL = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOADED,
        ST_WORD,
        ST_CLEAR_ALL,
        ST_FILL_ALL
    } st_e;
endpackage

// File: rtl/prog_seq_sync.sv
module prog_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/prog_seq_lowtimer.sv
module prog_seq_lowtimer #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic long_enough
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (level) begin
            cnt <= '0;
        end else if (cnt != CW'(MIN_LOW)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign long_enough = (cnt == CW'(MIN_LOW));
endmodule

// File: rtl/prog_seq_status.sv
module prog_seq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic low_ok,
    input  logic busy,
    output logic dout,
    output logic dout_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_oe <= 1'b0;
        end else if (cs_fall) begin
            dout_oe <= 1'b0;
        end else if (cs_rise && busy && low_ok) begin
            dout_oe <= 1'b1;
        end
    end

    assign dout = ~busy;
endmodule

// File: rtl/prog_seq_fsm.sv
module prog_seq_fsm
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int T_WORD = 40,
    parameter int T_ERAL = 60,
    parameter int T_WRAL = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              permit,
    input  logic              cs_fall,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_we_all,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int T_FILL = T_WRAL - T_ERAL;
    localparam int TW     = $clog2(T_WRAL + 1);

    st_e               state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [TW-1:0]     tmr;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_ERASE;
            addr_q <= '0;
            data_q <= '0;
            tmr    <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_LOADED: begin
                    if (cmd_valid) begin
                        if (permit) begin
                            state  <= ST_LOADED;
                            op_q   <= cmd_op;
                            addr_q <= cmd_addr;
                            data_q <= cmd_data;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end else if (state == ST_LOADED && cs_fall) begin
                        unique case (op_q)
                            OP_ERASE, OP_WRITE: begin
                                state <= ST_WORD;
                                tmr   <= TW'(T_WORD - 1);
                            end
                            OP_ERASE_ALL, OP_WRITE_ALL: begin
                                state <= ST_CLEAR_ALL;
                                tmr   <= TW'(T_ERAL - 1);
                            end
                        endcase
                    end
                end
                ST_WORD: begin
                    if (last) state <= ST_IDLE;
                    else      tmr   <= tmr - 1'b1;
                end
                ST_CLEAR_ALL: begin
                    if (last) begin
                        if (op_q == OP_WRITE_ALL) begin
                            state <= ST_FILL_ALL;
                            tmr   <= TW'(T_FILL - 1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_FILL_ALL: begin
                    if (last) state <= ST_IDLE;
                    else      tmr   <= tmr - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        last       = (tmr == '0);
        busy       = (state == ST_WORD) || (state == ST_CLEAR_ALL) || (state == ST_FILL_ALL);
        mem_we     = (state == ST_WORD) && last;
        mem_we_all = ((state == ST_CLEAR_ALL) || (state == ST_FILL_ALL)) && last;
        mem_addr   = addr_q;
        if ((state == ST_WORD && op_q == OP_WRITE) || state == ST_FILL_ALL)
            mem_wdata = data_q;
        else
            mem_wdata = '1;
    end
endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_LOW_CLKS = 4,
    parameter int T_WORD_CLKS  = 40,
    parameter int T_ERAL_CLKS  = 60,
    parameter int T_WRAL_CLKS  = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              permit,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_we_all,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dout,
    output logic              dout_oe
);
    logic cs_level;
    logic cs_rise;
    logic cs_fall;
    logic low_ok;

    prog_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cs),
        .level    (cs_level),
        .rise     (cs_rise),
        .fall     (cs_fall)
    );

    prog_seq_lowtimer #(.MIN_LOW(MIN_LOW_CLKS)) u_low (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (cs_level),
        .long_enough (low_ok)
    );

    prog_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .T_WORD (T_WORD_CLKS),
        .T_ERAL (T_ERAL_CLKS),
        .T_WRAL (T_WRAL_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_e'(cmd_op)),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .permit     (permit),
        .cs_fall    (cs_fall),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_we_all (mem_we_all),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    prog_seq_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall),
        .low_ok  (low_ok),
        .busy    (busy),
        .dout    (dout),
        .dout_oe (dout_oe)
    );
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_fall,
    input logic busy,
    input logic mem_we,
    input logic mem_we_all,
    input logic dout_oe
);
    p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_fall));

    p_word_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !busy);

    p_strobe_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_we_all) |-> busy);

    p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_we_all));

    p_oe_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(busy));

    p_oe_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !dout_oe);

    p_run_to_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we && !mem_we_all) |=> busy);
endmodule

bind prog_seq prog_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_we_all (mem_we_all),
    .dout_oe    (dout_oe)
);

// File: tb/prog_seq_test.sv
module prog_seq_test;
    localparam int AW      = 8;
    localparam int DW      = 16;
    localparam int MIN_LOW = 4;
    localparam int T_WORD  = 40;
    localparam int T_ERAL  = 60;
    localparam int T_WRAL  = 120;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          permit = 1'b0;
    logic          busy, mem_we, mem_we_all, dout, dout_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    always #2 clk = ~clk;

    prog_seq uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .permit(permit), .busy(busy),
        .mem_we(mem_we), .mem_we_all(mem_we_all), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        bit            all;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    exp_t  mon_e;
    string mon_r;
    int    checks = 0;
    int    errors = 0;
    int    run = 0;
    int    last_run = 0;
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_strobe(input bit all, input logic [AW-1:0] a,
                                 input logic [DW-1:0] d, input string req);
        exp_t e;
        e.all = all; e.addr = a; e.data = d;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; permit = ok;
        @(negedge clk);
        cmd_valid = 1'b0; permit = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every strobe, tracks busy run length
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_we_all)) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected strobe actual=%0h expected=none", mem_wdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_r = req_q.pop_front();
                chk(mem_we_all == mon_e.all, {mon_r, " strobe kind"}, mem_we_all, mon_e.all);
                chk(mem_wdata == mon_e.data, {mon_r, " data"}, mem_wdata, mon_e.data);
                if (!mon_e.all)
                    chk(mem_addr == mon_e.addr, {mon_r, " addr"}, mem_addr, mon_e.addr);
            end
        end
        if (busy) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int len, input string req);
        send_cmd(op, a, d, 1'b1);
        last_run = 0;
        @(negedge clk);
        cs = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R2 busy before start", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy at start", busy, 1);
        repeat (len + 4) @(negedge clk);
        chk(last_run == len, {"R3 busy length ", req}, last_run, len);
        chk(exp_q.size() == 0, {req, " strobes delivered"}, exp_q.size(), 0);
        chk(dout_oe == 1'b0, "R10 no status when cs held low", dout_oe, 0);
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 0 && dout_oe == 0 && mem_we == 0 && mem_we_all == 0,
            "R1 outputs in reset", {busy, dout_oe, mem_we, mem_we_all}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 0 && dout_oe == 0, "R1 outputs after reset", {busy, dout_oe}, 0);

        // word write, word erase, erase-all, write-all
        expect_strobe(1'b0, 8'h3C, 16'hA5C3, "R4");
        do_op(2'b01, 8'h3C, 16'hA5C3, T_WORD, "R4");
        expect_strobe(1'b0, 8'hF0, 16'hFFFF, "R5");
        do_op(2'b00, 8'hF0, 16'h1234, T_WORD, "R5");
        expect_strobe(1'b1, 8'h00, 16'hFFFF, "R6");
        do_op(2'b10, 8'h11, 16'h0000, T_ERAL, "R6");
        expect_strobe(1'b1, 8'h00, 16'hFFFF, "R7 erase phase");
        expect_strobe(1'b1, 8'h00, 16'h5A0F, "R7 fill phase");
        do_op(2'b11, 8'h22, 16'h5A0F, T_WRAL, "R7");

        // refused command, alone and over a loaded one
        send_cmd(2'b01, 8'h01, 16'h0001, 1'b0);
        last_run = 0;
        cs = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 0 && last_run == 0, "R8 refused command idle", busy, 0);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        send_cmd(2'b01, 8'h02, 16'h0002, 1'b1);
        send_cmd(2'b10, 8'h03, 16'h0003, 1'b0);
        cs = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 0 && last_run == 0, "R8 refused replaces loaded", busy, 0);
        cs = 1'b1;
        repeat (4) @(negedge clk);

        // status after a long low time
        expect_strobe(1'b0, 8'h44, 16'h4444, "R9");
        send_cmd(2'b01, 8'h44, 16'h4444, 1'b1);
        cs = 1'b0;
        repeat (MIN_LOW + 3) @(negedge clk);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        chk(dout_oe == 1'b1, "R9 status enabled", dout_oe, 1);
        chk(dout == 1'b0, "R9 status busy", dout, 0);
        chk(busy == 1'b1, "R12 cycle continues with cs high", busy, 1);
        repeat (T_WORD + 4) @(negedge clk);
        chk(dout_oe == 1'b1 && dout == 1'b1, "R9 status ready", {dout_oe, dout}, 2'b11);
        chk(exp_q.size() == 0, "R9 strobe delivered", exp_q.size(), 0);
        cs = 1'b0;
        repeat (3) @(negedge clk);
        chk(dout_oe == 1'b0, "R11 status off on cs fall", dout_oe, 0);
        cs = 1'b1;
        repeat (4) @(negedge clk);

        // short low glitch gives no status
        expect_strobe(1'b0, 8'h55, 16'hFFFF, "R10");
        send_cmd(2'b00, 8'h55, 16'h5555, 1'b1);
        cs = 1'b0;
        repeat (2) @(negedge clk);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b1 && dout_oe == 1'b0, "R10 short low no status", {busy, dout_oe}, 2'b10);
        repeat (T_WORD + 4) @(negedge clk);
        chk(dout_oe == 1'b0, "R10 still no status", dout_oe, 0);
        chk(exp_q.size() == 0, "R10 strobe delivered", exp_q.size(), 0);

        // command during busy is ignored
        expect_strobe(1'b0, 8'h66, 16'h6666, "R12");
        send_cmd(2'b01, 8'h66, 16'h6666, 1'b1);
        last_run = 0;
        cs = 1'b0;
        repeat (6) @(negedge clk);
        cs = 1'b1;
        repeat (4) @(negedge clk);
        send_cmd(2'b10, 8'h77, 16'h7777, 1'b1);
        repeat (T_WORD) @(negedge clk);
        chk(last_run == T_WORD, "R12 cycle not restarted", last_run, T_WORD);
        cs = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R12 ignored command starts nothing", busy, 0);
        chk(exp_q.size() == 0, "R12 strobe delivered", exp_q.size(), 0);
        cs = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule